// File: doc/BRIEF.md
# Aging-Priority Output Contention Arbiter

This block decides, once per clock, which buffered packet each switch output serves. Every occupied buffer slot holds a request vector with one bit per output and a small priority number. For every output whose downstream neighbour signals that it can accept traffic, the arbiter picks the requesting slot with the largest priority. It drives that slot's index on the output's grant lane, which carries the identity both to the output side and to the fabric.

A slot that asked for at least one open output and won nothing has its priority raised by one, so a waiting packet keeps gaining ground until it wins. Multicast packets keep their slot until every requested output has been served; each served bit is cleared as it is granted. New packets enter through a single load port that writes one free slot per cycle.

Top module: `aging_prio_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every grant_valid bit and every slot_busy bit is 0.
- R2: A round happens on every clock edge. For each output o with fc_ok[o]=1, the occupied slot with request bit o set and the greatest priority wins. grant_valid[o] and grant_idx for o show the outcome in the cycle after that edge.
- R3: The grant index of output o sits at grant_idx[o*IDX_W +: IDX_W]. A slot that requests several open outputs can win all of them in the same round.
- R4: When priorities are equal, the slot with the lowest index wins.
- R5: A newly loaded slot starts at priority 0. A slot that requested at least one output with fc_ok set and won none of them has its priority raised by 1 for the next round.
- R6: An output with fc_ok=0 produces no grant in the next cycle. Its requests leave the slots unchanged and do not count as a lost round.
- R7: Each granted request bit is cleared. When a slot's vector becomes all-zero, slot_busy for it goes to 0 in the cycle after the round and its priority returns to 0.
- R8: Priority stops at its maximum value 2^PRIO_W-1 and never wraps to 0.
- R9: A load (load_en=1) writes load_req into slot load_slot only if that slot is free before the edge and load_req is nonzero. A load that fails either condition leaves the slot as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Load a packet this cycle |
| load_slot | input | IDX_W | Buffer slot to load |
| load_req | input | NUM_OUTS | Request vector of the loaded packet, bit o asks for output o |
| fc_ok | input | NUM_OUTS | Downstream flow control per output, 1 = may grant |
| grant_valid | output | NUM_OUTS | Registered grant present per output |
| grant_idx | output | NUM_OUTS*IDX_W | Registered winning slot index per output, packed lane by lane |
| slot_busy | output | NUM_SLOTS | Slot occupied per buffer entry |

## Verification
The bench builds the arbiter with four slots, two outputs and a two-bit priority. With a ceiling of 3, random traffic with heavy contention drives slots into saturation within a few rounds, and a wrapping counter would then change the winners the reference model predicts. Two outputs are enough to cover multicast packets that are only partly served, and rounds where one output is blocked while the other is granted. Four slots keep index ties frequent. Directed sequences cover lowest-index tie-break, an aged packet beating a newer packet with a lower index, blocked rounds that must not age a packet, and loads refused because the slot is occupied or the vector is empty.

// File: rtl/aparb_pkg.sv
package aparb_pkg;

   // index width for a count of entries, never below 1
   function automatic int idx_bits(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/aparb_slot.sv
module aparb_slot
   import aparb_pkg::*;
#(
   parameter int NUM_OUTS = 2,
   parameter int PRIO_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_hit,
   input  logic [NUM_OUTS-1:0] load_req,
   input  logic [NUM_OUTS-1:0] fc_ok,
   input  logic [NUM_OUTS-1:0] win_vec,
   output logic                busy,
   output logic [NUM_OUTS-1:0] req,
   output logic [PRIO_W-1:0]   prio
);

   localparam logic [PRIO_W-1:0] PMAX = {PRIO_W{1'b1}};

   logic                busy_q;
   logic [NUM_OUTS-1:0] req_q;
   logic [PRIO_W-1:0]   prio_q;
   logic                contended;
   logic                won_any;
   logic [NUM_OUTS-1:0] req_left;

   always_comb begin
      contended = busy_q && (|(req_q & fc_ok));
      won_any   = |win_vec;
      req_left  = req_q & ~win_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         req_q  <= '0;
         prio_q <= '0;
      end else if (busy_q) begin
         req_q <= req_left;
         if (req_left == '0) begin
            busy_q <= 1'b0;
            prio_q <= '0;
         end else if (contended && !won_any && prio_q != PMAX) begin
            prio_q <= prio_q + 1'b1;
         end
      end else if (load_hit && (|load_req)) begin
         busy_q <= 1'b1;
         req_q  <= load_req;
         prio_q <= '0;
      end
   end

   assign busy = busy_q;
   assign req  = req_q;
   assign prio = prio_q;

   // R5
   prio_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> (prio_q == $past(prio_q) || prio_q == $past(prio_q) + 1'b1));

   // R8
   prio_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && $past(prio_q) == PMAX) |-> (prio_q == PMAX));

   // R5
   load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !$past(busy_q)) |-> (prio_q == '0 && req_q != '0));

   // R7
   grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_q) && busy_q) |-> ((req_q & $past(win_vec)) == '0));

endmodule

// File: rtl/aparb_column.sv
module aparb_column
   import aparb_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int PRIO_W    = 2,
   parameter int IDX_W     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable,
   input  logic [NUM_SLOTS-1:0]        col_req,
   input  logic [NUM_SLOTS*PRIO_W-1:0] prio_flat,
   output logic                        pick_vld,
   output logic [IDX_W-1:0]            pick_idx
);

   logic              found;
   logic [IDX_W-1:0]  best_i;
   logic [PRIO_W-1:0] best_p;

   // ascending scan, strict compare: equal priority keeps the lower index
   always_comb begin
      found  = 1'b0;
      best_i = '0;
      best_p = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (enable && col_req[s] &&
             (!found || prio_flat[s*PRIO_W +: PRIO_W] > best_p)) begin
            found  = 1'b1;
            best_i = IDX_W'(s);
            best_p = prio_flat[s*PRIO_W +: PRIO_W];
         end
      end
   end

   assign pick_vld = found;
   assign pick_idx = best_i;

   // R6
   blocked_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !pick_vld);

   // R2
   pick_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_vld |-> col_req[pick_idx]);

   // R2
   pick_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (|col_req)) |-> pick_vld);

   // R4
   always @(posedge clk) begin
      if (rst_n && pick_vld) begin
         for (int s = 0; s < NUM_SLOTS; s++) begin
            if (col_req[s]) begin
               pick_max_chk: assert (prio_flat[s*PRIO_W +: PRIO_W] < prio_flat[pick_idx*PRIO_W +: PRIO_W]
                  || (prio_flat[s*PRIO_W +: PRIO_W] == prio_flat[pick_idx*PRIO_W +: PRIO_W]
                      && IDX_W'(s) >= pick_idx));
            end
         end
      end
   end

endmodule

// File: rtl/aging_prio_arbiter.sv
module aging_prio_arbiter
   import aparb_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int NUM_OUTS  = 4,
   parameter int PRIO_W    = 3,
   parameter int IDX_W     = idx_bits(NUM_SLOTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_en,
   input  logic [IDX_W-1:0]          load_slot,
   input  logic [NUM_OUTS-1:0]       load_req,
   input  logic [NUM_OUTS-1:0]       fc_ok,
   output logic [NUM_OUTS-1:0]       grant_valid,
   output logic [NUM_OUTS*IDX_W-1:0] grant_idx,
   output logic [NUM_SLOTS-1:0]      slot_busy
);

   localparam int PRIO_BITS = NUM_SLOTS * PRIO_W;

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("aging_prio_arbiter: NUM_SLOTS must be at least 2");
      end
      if (NUM_OUTS < 1) begin : g_bad_outs
         $error("aging_prio_arbiter: NUM_OUTS must be at least 1");
      end
      if (PRIO_W < 1) begin : g_bad_prio
         $error("aging_prio_arbiter: PRIO_W must be at least 1");
      end
      if ((1 << IDX_W) < NUM_SLOTS) begin : g_bad_idx
         $error("aging_prio_arbiter: IDX_W too narrow for NUM_SLOTS");
      end
   endgenerate

   logic [NUM_SLOTS-1:0]      busy_v;
   logic [NUM_OUTS-1:0]       req_m  [NUM_SLOTS];
   logic [NUM_OUTS-1:0]       win_m  [NUM_SLOTS];
   logic [PRIO_BITS-1:0]      prio_flat;
   logic [NUM_SLOTS-1:0]      col_req [NUM_OUTS];
   logic [NUM_OUTS-1:0]       pick_vld;
   logic [IDX_W-1:0]          pick_idx [NUM_OUTS];
   logic [NUM_OUTS-1:0]       gv_q;
   logic [NUM_OUTS*IDX_W-1:0] gi_q;

   // one state holder per buffer entry
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic load_hit;
      assign load_hit = load_en && (load_slot == IDX_W'(s));

      for (genvar o = 0; o < NUM_OUTS; o++) begin : g_win
         assign win_m[s][o] = pick_vld[o] && (pick_idx[o] == IDX_W'(s));
      end

      aparb_slot #(
         .NUM_OUTS (NUM_OUTS),
         .PRIO_W   (PRIO_W)
      ) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_hit (load_hit),
         .load_req (load_req),
         .fc_ok    (fc_ok),
         .win_vec  (win_m[s]),
         .busy     (busy_v[s]),
         .req      (req_m[s]),
         .prio     (prio_flat[s*PRIO_W +: PRIO_W])
      );
   end

   // one contention column per output
   for (genvar o = 0; o < NUM_OUTS; o++) begin : g_col
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_req
         assign col_req[o][s] = busy_v[s] && req_m[s][o];
      end

      aparb_column #(
         .NUM_SLOTS (NUM_SLOTS),
         .PRIO_W    (PRIO_W),
         .IDX_W     (IDX_W)
      ) col_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (fc_ok[o]),
         .col_req   (col_req[o]),
         .prio_flat (prio_flat),
         .pick_vld  (pick_vld[o]),
         .pick_idx  (pick_idx[o])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gv_q[o]                  <= 1'b0;
            gi_q[o*IDX_W +: IDX_W]   <= '0;
         end else begin
            gv_q[o]                  <= pick_vld[o];
            gi_q[o*IDX_W +: IDX_W]   <= pick_vld[o] ? pick_idx[o] : '0;
         end
      end

      // R6
      grant_fc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         gv_q[o] |-> $past(fc_ok[o]));
   end

   assign grant_valid = gv_q;
   assign grant_idx   = gi_q;
   assign slot_busy   = busy_v;

   // R7
   free_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_v != '0) |-> ((busy_v & ~$past(busy_v)) == '0 || $past(load_en)));

endmodule

// File: tb/aging_prio_arbiter_tb_top.sv
module aging_prio_arbiter_tb_top;

   localparam int NS = 4;
   localparam int NO = 2;
   localparam int PW = 2;
   localparam int IW = 2;
   localparam int PMAX = (1 << PW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [IW-1:0] load_slot = '0;
   logic [NO-1:0] load_req = '0;
   logic [NO-1:0] fc_ok = '0;
   logic [NO-1:0] grant_valid;
   logic [NO*IW-1:0] grant_idx;
   logic [NS-1:0] slot_busy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference state
   int m_valid [NS];
   int m_req   [NS][NO];
   int m_prio  [NS];
   int e_gv    [NO];
   int e_gi    [NO];

   always #2 clk = ~clk;

   aging_prio_arbiter #(
      .NUM_SLOTS (NS),
      .NUM_OUTS  (NO),
      .PRIO_W    (PW),
      .IDX_W     (IW)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_en     (load_en),
      .load_slot   (load_slot),
      .load_req    (load_req),
      .fc_ok       (fc_ok),
      .grant_valid (grant_valid),
      .grant_idx   (grant_idx),
      .slot_busy   (slot_busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int gidx(input int o);
      return int'(grant_idx[o*IW +: IW]);
   endfunction

   // behavioural reference for one round, computed from the pre-edge state
   task automatic model_round(input bit le, input int ls, input int lr, input int fc);
      int win [NO];
      int pre_valid [NS];
      for (int s = 0; s < NS; s++) pre_valid[s] = m_valid[s];
      for (int o = 0; o < NO; o++) begin
         win[o] = -1;
         if (fc[o]) begin
            for (int s = 0; s < NS; s++) begin
               if (m_valid[s] != 0 && m_req[s][o] != 0 &&
                   (win[o] < 0 || m_prio[s] > m_prio[win[o]])) win[o] = s;
            end
         end
         e_gv[o] = (win[o] >= 0);
         e_gi[o] = (win[o] >= 0) ? win[o] : 0;
      end
      for (int s = 0; s < NS; s++) begin
         if (m_valid[s] != 0) begin
            bit cont;
            bit won;
            bit left;
            cont = 0; won = 0; left = 0;
            for (int o = 0; o < NO; o++) begin
               if (fc[o] && m_req[s][o] != 0) cont = 1;
               if (win[o] == s) begin won = 1; m_req[s][o] = 0; end
               if (m_req[s][o] != 0) left = 1;
            end
            if (!left) begin
               m_valid[s] = 0;
               m_prio[s] = 0;
            end else if (cont && !won && m_prio[s] < PMAX) begin
               m_prio[s]++;
            end
         end
      end
      if (le && pre_valid[ls] == 0 && lr != 0) begin
         m_valid[ls] = 1;
         m_prio[ls] = 0;
         for (int o = 0; o < NO; o++) m_req[ls][o] = (lr >> o) & 1;
      end
   endtask

   task automatic compare_all();
      for (int o = 0; o < NO; o++) begin
         chk(int'(grant_valid[o]) == e_gv[o], "R2 R6 grant_valid", int'(grant_valid[o]), e_gv[o]);
         if (e_gv[o] != 0)
            chk(gidx(o) == e_gi[o], "R3 R4 R5 R8 grant_idx", gidx(o), e_gi[o]);
      end
      for (int s = 0; s < NS; s++)
         chk(int'(slot_busy[s]) == m_valid[s], "R7 R9 slot_busy", int'(slot_busy[s]), m_valid[s]);
   endtask

   // drive at the falling edge, update model, let the rising edge act, compare at the next falling edge
   task automatic step(input bit le, input int ls, input int lr, input int fc);
      load_en   = le;
      load_slot = IW'(ls);
      load_req  = NO'(lr);
      fc_ok     = NO'(fc);
      model_round(le, ls, lr, fc);
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      for (int s = 0; s < NS; s++) begin
         m_valid[s] = 0; m_prio[s] = 0;
         for (int o = 0; o < NO; o++) m_req[s][o] = 0;
      end
      for (int o = 0; o < NO; o++) begin e_gv[o] = 0; e_gi[o] = 0; end

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(grant_valid == '0, "R1 grant_valid in reset", int'(grant_valid), 0);
      chk(slot_busy == '0, "R1 slot_busy in reset", int'(slot_busy), 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(grant_valid == '0, "R1 grant_valid after reset", int'(grant_valid), 0);
      chk(slot_busy == '0, "R1 slot_busy after reset", int'(slot_busy), 0);

      // R4: equal priority, lower index wins
      step(1, 2, 1, 0);
      step(1, 1, 1, 0);
      step(0, 0, 0, 1);
      chk(grant_valid[0] && gidx(0) == 1, "R4 tie to lowest index", gidx(0), 1);
      step(0, 0, 0, 1);
      chk(grant_valid[0] && gidx(0) == 2, "R2 remaining requester", gidx(0), 2);
      chk(slot_busy == '0, "R7 slots freed", int'(slot_busy), 0);

      // R5: an aged slot beats a fresh slot with a lower index
      step(1, 3, 1, 0);
      step(1, 1, 1, 0);
      step(1, 0, 1, 1);
      chk(gidx(0) == 1, "R4 first winner", gidx(0), 1);
      step(0, 0, 0, 1);
      chk(grant_valid[0] && gidx(0) == 3, "R5 aged slot wins", gidx(0), 3);
      step(0, 0, 0, 1);
      chk(grant_valid[0] && gidx(0) == 0, "R5 fresh slot served last", gidx(0), 0);

      // R6: blocked rounds neither grant nor age
      step(1, 3, 2, 1);
      step(0, 0, 0, 1);
      step(0, 0, 0, 1);
      chk(grant_valid[1] == 1'b0, "R6 blocked output silent", int'(grant_valid[1]), 0);
      chk(slot_busy[3] == 1'b1, "R6 blocked slot kept", int'(slot_busy[3]), 1);
      step(1, 2, 2, 1);
      step(0, 0, 0, 2);
      chk(grant_valid[1] && gidx(1) == 2, "R6 blocked slot not aged", gidx(1), 2);
      step(0, 0, 0, 2);
      chk(grant_valid[1] && gidx(1) == 3, "R6 later grant", gidx(1), 3);

      // R7 and R9: partly served multicast, refused loads
      step(1, 1, 3, 0);
      step(0, 0, 0, 1);
      chk(grant_valid[0] && gidx(0) == 1, "R7 multicast first leg", gidx(0), 1);
      chk(slot_busy[1] == 1'b1, "R7 slot held for second leg", int'(slot_busy[1]), 1);
      step(1, 1, 1, 0);
      step(0, 0, 0, 1);
      chk(grant_valid[0] == 1'b0, "R9 load into busy slot ignored", int'(grant_valid[0]), 0);
      step(0, 0, 0, 2);
      chk(grant_valid[1] && gidx(1) == 1, "R7 multicast second leg", gidx(1), 1);
      chk(slot_busy[1] == 1'b0, "R7 slot freed when vector empty", int'(slot_busy[1]), 0);
      step(1, 1, 3, 0);
      step(0, 0, 0, 3);
      chk(grant_valid == 2'b11 && gidx(0) == 1 && gidx(1) == 1, "R3 both outputs same slot",
          int'(grant_idx), 5);
      step(1, 2, 0, 0);
      step(0, 0, 0, 0);
      chk(slot_busy[2] == 1'b0, "R9 empty vector refused", int'(slot_busy[2]), 0);

      // random traffic, heavy contention pushes priorities into saturation (R8)
      for (int i = 0; i < 4000; i++) begin
         int fc;
         fc = (($urandom % 8) == 0) ? int'($urandom % 4) : 3;
         if (($urandom % 4) == 0) fc = int'($urandom % 4);
         step(($urandom % 3) != 0, int'($urandom % NS), int'($urandom % 4), fc);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule